// File: doc/BRIEF.md
# DRAM Row Access Sequencer with Periodic Refresh

This block drives a small behavioural one-transistor DRAM array. Reading the array is destructive, so every access runs a fixed sequence of phases: the bitlines are precharged to mid level, the wordline is raised, the sense amplifier fires and latches the row, and the latched row (or the new write data) is then written back into the same row. Each phase length is a parameter given in clock cycles.

The host uses a request/acknowledge port. It raises `req` together with `we`, `addr` and `wdata`, and holds them until `ack` pulses. `rdata` carries the row contents that were sensed. An internal interval timer raises refresh requests. Each refresh cycle senses and restores the row named by an internal refresh row counter. Refresh requests are interleaved with host traffic, and `refresh_busy` is high while a refresh cycle is running.

The array model clears a row when that row is sensed, and it clears any row that has not been restored within a retention window. A missing restore or a stalled refresh therefore shows up as lost data.

Top module: `dram_row_ctl`

## Requirements
- R1: After reset `ack` and `refresh_busy` are low, and every row reads back as zero.
- R2: Every access runs the phases precharge (T_PRE), wordline-to-sense (T_WL), sense (T_SENSE) and restore (T_RESTORE) in that order. When no refresh is pending, `ack` rises exactly T_PRE+T_WL+T_SENSE+T_RESTORE cycles after the first edge that samples `req` high. That is 7 cycles with the defaults.
- R3: `ack` is a single-cycle pulse in the last restore cycle, and `rdata` is valid in that same cycle.
- R4: A read returns the stored word and writes it back, so repeated reads of a row return the same value.
- R5: A write stores `wdata` into the addressed row, and `rdata` at the write's `ack` shows the row's previous contents.
- R6: The refresh timer requests a refresh every REF_INTERVAL cycles. With no host traffic, refresh cycles start exactly REF_INTERVAL cycles apart, and `refresh_busy` stays high for exactly the length of one access (7 cycles by default).
- R7: The refresh row counter visits rows 0 to ROWS-1 and wraps. Rows left idle for far longer than the retention window therefore keep their data.
- R8: A pending refresh waits for a running host access to finish, including its restore, and beats a waiting host request. A request raised in the first cycle of a refresh gets its `ack` 2×(phase sum) cycles later, which is 14 by default.
- R9: `ack` is never high while `refresh_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host access request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ROW_W | Row address |
| wdata | input | WIDTH | Write data |
| ack | output | 1 | Single-cycle completion pulse |
| rdata | output | WIDTH | Sensed row contents, valid with `ack` |
| refresh_busy | output | 1 | High while a refresh cycle runs |

## Verification
A skipped or misdirected restore turns the next read of that row into zero, which is visible on `rdata` one access (7 cycles) later. A refresh counter that does not advance or does not wrap leaves some rows unrefreshed. The retention window then clears them, and the loss appears at the first read after roughly two refresh sweeps. A wrong phase count or a broken priority between refresh and host requests shifts the `ack` cycle, and the bench measures that shift exactly.

// File: rtl/dram_rowctl_pkg.sv
// Shared types for the DRAM row controller.
// Assumes: nothing beyond the standard language.
package dram_rowctl_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_WL,
        PH_SENSE,
        PH_RESTORE
    } phase_e;
endpackage

// File: rtl/drc_refresh_timer.sv
// Interval timer and refresh row pointer.
// Raises ref_pending every REF_INTERVAL cycles and drops it once the sequencer
// grants the refresh. Steps the row pointer when a refresh cycle finishes.
// Assumes: REF_INTERVAL is longer than one access, ROWS >= 2.
module drc_refresh_timer #(
    parameter int ROWS         = 8,
    parameter int REF_INTERVAL = 200,
    localparam int ROW_W       = $clog2(ROWS),
    localparam int TW          = $clog2(REF_INTERVAL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_grant,
    input  logic             ref_done,
    output logic             ref_pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam logic [TW-1:0]    TICK_LAST = TW'(REF_INTERVAL - 1);
    localparam logic [ROW_W-1:0] ROW_LAST  = ROW_W'(ROWS - 1);

    logic [TW-1:0] tick_q;

    // Free-running interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                tick_q <= '0;
        else if (tick_q == TICK_LAST) tick_q <= '0;
        else                       tick_q <= tick_q + 1'b1;
    end

    // Pending flag: set when the interval expires, cleared on grant.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ref_pending <= 1'b0;
        else if (tick_q == TICK_LAST) ref_pending <= 1'b1;
        else if (ref_grant)           ref_pending <= 1'b0;
    end

    // Refresh row pointer, wrapping after the last row.
    always_ff @(posedge clk) begin
        if (!rst_n)                ref_row <= '0;
        else if (ref_done)         ref_row <= (ref_row == ROW_LAST) ? '0 : ref_row + 1'b1;
    end

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pending && !ref_grant) |=> ref_pending);  // R8
    AST_GRANT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> ref_pending);  // R6
endmodule

// File: rtl/drc_cell_array.sv
// Behavioural destructive-read storage array.
// Sensing a row copies it into the sense latch and clears the row. A restore
// writes the row and restarts its retention age. A row whose age reaches
// RETAIN without a restore is cleared.
// Assumes: sense and restore never fall in the same cycle.
module drc_cell_array #(
    parameter int ROWS   = 8,
    parameter int WIDTH  = 16,
    parameter int RETAIN = 3200,
    localparam int ROW_W = $clog2(ROWS),
    localparam int AGE_W = $clog2(RETAIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sense_fire,
    input  logic [ROW_W-1:0] sense_row,
    input  logic             restore_en,
    input  logic [ROW_W-1:0] restore_row,
    input  logic [WIDTH-1:0] restore_data,
    output logic [WIDTH-1:0] sense_data
);
    logic [WIDTH-1:0] row_q [ROWS];
    logic [AGE_W-1:0] age_q [ROWS];

    // Per-row storage: restore, destructive sense, and retention decay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) begin
                row_q[i] <= '0;
                age_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ROWS; i++) begin
                if (restore_en && restore_row == ROW_W'(i)) begin
                    row_q[i] <= restore_data;
                    age_q[i] <= '0;
                end else begin
                    if (sense_fire && sense_row == ROW_W'(i))
                        row_q[i] <= '0;
                    else if (age_q[i] == AGE_W'(RETAIN - 1))
                        row_q[i] <= '0;
                    if (age_q[i] != AGE_W'(RETAIN))
                        age_q[i] <= age_q[i] + 1'b1;
                end
            end
        end
    end

    // Sense amplifier latch: captures the row when the sense phase opens.
    always_ff @(posedge clk) begin
        if (!rst_n)          sense_data <= '0;
        else if (sense_fire) sense_data <= row_q[sense_row];
    end

    AST_SENSE_NOT_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        sense_fire |-> !restore_en);  // R4
endmodule

// File: rtl/drc_sequencer.sv
// Phase sequencer for one row access (host or refresh).
// Steps IDLE -> PRE -> WL -> SENSE -> RESTORE -> IDLE, each phase lasting its
// parameter count of cycles. A pending refresh is chosen ahead of a host
// request, and only in IDLE, so a running access always completes first.
// Assumes: host holds req and its fields stable until ack; all T_* >= 1.
module drc_sequencer
    import dram_rowctl_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int WIDTH     = 16,
    parameter int T_PRE     = 2,
    parameter int T_WL      = 2,
    parameter int T_SENSE   = 1,
    parameter int T_RESTORE = 2,
    localparam int ROW_W    = $clog2(ROWS),
    localparam int MAX_AB   = (T_PRE > T_WL) ? T_PRE : T_WL,
    localparam int MAX_CD   = (T_SENSE > T_RESTORE) ? T_SENSE : T_RESTORE,
    localparam int MAX_T    = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD,
    localparam int CNT_W    = $clog2(MAX_T + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_req,
    input  logic             host_we,
    input  logic [ROW_W-1:0] host_addr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             ref_pending,
    input  logic [ROW_W-1:0] ref_row,
    input  logic [WIDTH-1:0] sense_data,
    output logic             ref_grant,
    output logic             ref_done,
    output logic             sense_fire,
    output logic [ROW_W-1:0] op_row,
    output logic             restore_en,
    output logic [WIDTH-1:0] restore_data,
    output logic             host_ack,
    output logic             refresh_busy
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             op_ref_q;
    logic             op_we_q;
    logic [WIDTH-1:0] op_wdata_q;
    logic [CNT_W-1:0] last_cnt;
    logic             phase_last;

    // Last count value of the current phase.
    always_comb begin
        unique case (phase_q)
            PH_PRE:     last_cnt = CNT_W'(T_PRE - 1);
            PH_WL:      last_cnt = CNT_W'(T_WL - 1);
            PH_SENSE:   last_cnt = CNT_W'(T_SENSE - 1);
            PH_RESTORE: last_cnt = CNT_W'(T_RESTORE - 1);
            default:    last_cnt = '0;
        endcase
        phase_last = (cnt_q == last_cnt);
    end

    // Phase state and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (phase_q == PH_IDLE) begin
            cnt_q <= '0;
            if (ref_pending || host_req) phase_q <= PH_PRE;
        end else if (!phase_last) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
            unique case (phase_q)
                PH_PRE:   phase_q <= PH_WL;
                PH_WL:    phase_q <= PH_SENSE;
                PH_SENSE: phase_q <= PH_RESTORE;
                default:  phase_q <= PH_IDLE;
            endcase
        end
    end

    // Operation capture at the start of an access; refresh has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_ref_q   <= 1'b0;
            op_we_q    <= 1'b0;
            op_row     <= '0;
            op_wdata_q <= '0;
        end else if (phase_q == PH_IDLE) begin
            if (ref_pending) begin
                op_ref_q <= 1'b1;
                op_we_q  <= 1'b0;
                op_row   <= ref_row;
            end else if (host_req) begin
                op_ref_q   <= 1'b0;
                op_we_q    <= host_we;
                op_row     <= host_addr;
                op_wdata_q <= host_wdata;
            end
        end
    end

    // Strobes toward the array, the timer and the host.
    always_comb begin
        ref_grant    = (phase_q == PH_IDLE) && ref_pending;
        sense_fire   = (phase_q == PH_SENSE) && (cnt_q == '0);
        restore_en   = (phase_q == PH_RESTORE) && phase_last;
        restore_data = (!op_ref_q && op_we_q) ? op_wdata_q : sense_data;
        host_ack     = restore_en && !op_ref_q;
        ref_done     = restore_en && op_ref_q;
        refresh_busy = op_ref_q && (phase_q != PH_IDLE);
    end

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WL) |-> ($past(phase_q) == PH_PRE || $past(phase_q) == PH_WL));  // R2
    AST_RESTORE_AFTER_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESTORE) |-> ($past(phase_q) == PH_SENSE || $past(phase_q) == PH_RESTORE));  // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);  // R3
    AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && ref_pending && host_req) |=> refresh_busy);  // R8
endmodule

// File: rtl/dram_row_ctl.sv
// Top level: host request/acknowledge port over a destructive-read DRAM
// array, with timer-driven refresh interleaved between host accesses.
// Assumes: req, we, addr and wdata stay stable from request until ack.
module dram_row_ctl #(
    parameter int ROWS         = 8,
    parameter int WIDTH        = 16,
    parameter int T_PRE        = 2,
    parameter int T_WL         = 2,
    parameter int T_SENSE      = 1,
    parameter int T_RESTORE    = 2,
    parameter int REF_INTERVAL = 200,
    parameter int RETAIN       = 2 * ROWS * REF_INTERVAL,
    localparam int ROW_W       = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [ROW_W-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    output logic             ack,
    output logic [WIDTH-1:0] rdata,
    output logic             refresh_busy
);
    logic             ref_pending, ref_grant, ref_done;
    logic [ROW_W-1:0] ref_row, op_row;
    logic             sense_fire, restore_en;
    logic [WIDTH-1:0] sense_data, restore_data;

    drc_refresh_timer #(.ROWS(ROWS), .REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk(clk), .rst_n(rst_n), .ref_grant(ref_grant), .ref_done(ref_done),
        .ref_pending(ref_pending), .ref_row(ref_row)
    );

    drc_sequencer #(.ROWS(ROWS), .WIDTH(WIDTH), .T_PRE(T_PRE), .T_WL(T_WL),
                    .T_SENSE(T_SENSE), .T_RESTORE(T_RESTORE)) u_seq (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_we(we),
        .host_addr(addr), .host_wdata(wdata), .ref_pending(ref_pending),
        .ref_row(ref_row), .sense_data(sense_data), .ref_grant(ref_grant),
        .ref_done(ref_done), .sense_fire(sense_fire), .op_row(op_row),
        .restore_en(restore_en), .restore_data(restore_data),
        .host_ack(ack), .refresh_busy(refresh_busy)
    );

    drc_cell_array #(.ROWS(ROWS), .WIDTH(WIDTH), .RETAIN(RETAIN)) u_array (
        .clk(clk), .rst_n(rst_n), .sense_fire(sense_fire), .sense_row(op_row),
        .restore_en(restore_en), .restore_row(op_row),
        .restore_data(restore_data), .sense_data(sense_data)
    );

    // The sensed row is the read data.
    assign rdata = sense_data;

    AST_ACK_NOT_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !refresh_busy);  // R9
endmodule

// File: tb/dram_row_ctl_bench.sv
module dram_row_ctl_bench;
    localparam int OP_LAT = 7;
    localparam int REF_INT = 200;
    localparam int NVEC = 13;
    // {we, addr[2:0], wdata[15:0], expected rdata[15:0]}
    localparam logic [35:0] VEC [NVEC] = '{
        36'h8_A5A5_0000, 36'hF_1234_0000, 36'h0_0000_A5A5, 36'h0_0000_A5A5,
        36'h7_0000_1234, 36'hB_FFFF_0000, 36'hB_0F0F_FFFF, 36'h3_0000_0F0F,
        36'h5_0000_0000, 36'hD_8001_0000, 36'h5_0000_8001, 36'h7_0000_1234,
        36'h0_0000_A5A5
    };

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
    logic [2:0] addr = '0;
    logic [15:0] wdata = '0;
    logic ack, refresh_busy;
    logic [15:0] rdata;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    dram_row_ctl u_dram_row_ctl (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .ack(ack), .rdata(rdata), .refresh_busy(refresh_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where ack was seen.
    task automatic host_op(input logic w, input logic [2:0] a, input logic [15:0] d,
                           output logic [15:0] rd, output int lat);
        req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!ack && lat < 60);
        rd = rdata;
        chk(!refresh_busy, "R9 busy at ack", refresh_busy, 0);
        req = 1'b0;
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        chk(1'b0, "watchdog", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd;
        int lat, gap, width, rises;
        repeat (3) @(negedge clk);
        chk(ack == 1'b0, "R1 ack in reset", ack, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ack == 1'b0 && refresh_busy == 1'b0, "R1 idle after reset", {ack, refresh_busy}, 0);

        // Table walk: latency, data and ack pulse width for each access.
        for (int i = 0; i < NVEC; i++) begin
            host_op(VEC[i][35], VEC[i][34:32], VEC[i][31:16], rd, lat);
            chk(lat == OP_LAT, $sformatf("R2 latency vec %0d", i), lat, OP_LAT);
            chk(rd == VEC[i][15:0], $sformatf("%s data vec %0d", VEC[i][35] ? "R5" : "R4", i),
                rd, VEC[i][15:0]);
            @(negedge clk);
            chk(ack == 1'b0, $sformatf("R3 ack pulse vec %0d", i), ack, 0);
        end

        // R6: refresh period and busy width with no host traffic.
        while (!refresh_busy) @(negedge clk);
        width = 0;
        while (refresh_busy) begin @(negedge clk); width++; end
        gap = width;
        while (!refresh_busy) begin @(negedge clk); gap++; end
        chk(width == OP_LAT, "R6 refresh busy width", width, OP_LAT);
        chk(gap == REF_INT, "R6 refresh period", gap, REF_INT);

        // R8: request raised in the first refresh cycle waits for it.
        while (refresh_busy) @(negedge clk);
        while (!refresh_busy) @(negedge clk);
        host_op(1'b0, 3'd0, 16'h0, rd, lat);
        chk(lat == 2 * OP_LAT, "R8 latency behind refresh", lat, 2 * OP_LAT);
        chk(rd == 16'hA5A5, "R8 data behind refresh", rd, 16'hA5A5);

        // R7: long idle, refresh must sweep and wrap to keep all rows.
        rises = 0;
        for (int c = 0; c < 6000; c++) begin
            logic prev;
            prev = refresh_busy;
            @(negedge clk);
            if (refresh_busy && !prev) rises++;
        end
        chk(rises >= 8, "R7 refresh count", rises, 8);
        while (refresh_busy) @(negedge clk);
        host_op(1'b0, 3'd0, 16'h0, rd, lat); chk(rd == 16'hA5A5, "R7 row0 kept", rd, 16'hA5A5);
        @(negedge clk);
        host_op(1'b0, 3'd3, 16'h0, rd, lat); chk(rd == 16'h0F0F, "R7 row3 kept", rd, 16'h0F0F);
        @(negedge clk);
        host_op(1'b0, 3'd5, 16'h0, rd, lat); chk(rd == 16'h8001, "R7 row5 kept", rd, 16'h8001);
        @(negedge clk);
        host_op(1'b0, 3'd7, 16'h0, rd, lat); chk(rd == 16'h1234, "R7 row7 kept", rd, 16'h1234);
        @(negedge clk);

        // R1: mid-run reset clears the array and the outputs.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ack == 1'b0 && refresh_busy == 1'b0, "R1 outputs in reset", {ack, refresh_busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        host_op(1'b0, 3'd0, 16'h0, rd, lat);
        chk(rd == 16'h0000, "R1 row cleared by reset", rd, 0);
        chk(lat == OP_LAT, "R2 latency after reset", lat, OP_LAT);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule